// File: doc/BRIEF.md
# Program Sequencer with Vectored Interrupts

This block produces the fetch address for a small microcontroller core whose program memory holds 1024 words of 14 bits. It keeps a 10-bit program counter and updates it once per cycle. The update follows a next-address code from the instruction decoder: hold, step, jump, call, return, or return-from-interrupt. Call and return save and restore addresses on a hidden 4-level hardware return stack. Only program counter values go on that stack. Software has no path to read or write the stack or its pointer.

Three interrupt sources feed the block: an external pin, a timer/event counter overflow and an A/D end-of-conversion. Each source has a pending flag, a per-source enable and its own fixed vector. A global enable gates all three. An interrupt is accepted only when the return stack still has a free level. Accepting an interrupt takes the place of the instruction at the current address. That address is pushed, the vector is loaded, the pending flag is cleared and the global enable drops. A return-from-interrupt raises the global enable again.

A call made with the stack full still jumps, but its return address is lost and an overflow pulse is raised. A return made with the stack empty reloads the bottom entry.

Top module: `pcseq_top`

## Requirements
- R1: While reset is held and after it is released, the program counter is 000h, the global enable is 0, no interrupt is pending, the overflow output is low and the stack is empty.
- R2: The next-address code `op_i` works as follows. Code 0 (hold) keeps the program counter. Code 1 (step) adds one, wrapping from 3FFh to 000h. Code 2 (jump) loads `target_i`. Codes 6 and 7 hold.
- R3: Code 3 (call) pushes the program counter plus one and loads `target_i`. Code 4 (return) loads the most recently pushed value. Up to 4 nested calls return in last-in, first-out order.
- R4: `irq_req_i` and `irq_en_i` use bit 0 for the external source (vector 004h), bit 1 for the timer (vector 008h) and bit 2 for the A/D source (vector 00Ch). When several sources qualify, the lowest bit wins.
- R5: An interrupt is accepted only when four things hold: the global enable is set, the source is pending, its enable bit is set and the stack is not full. On acceptance, the current program counter is pushed unchanged, the vector is loaded and `op_i` is ignored for that cycle.
- R6: A request bit high at a clock edge sets that source's pending flag, which is visible on `pend_o` after that edge. Accepting a source clears only its own flag. A request that is not accepted stays pending.
- R7: Accepting an interrupt clears the global enable. Code 5 (return-from-interrupt) pops like code 4 and sets the global enable. `gie_set_i` sets the global enable and `gie_clr_i` clears it.
- R8: A call made with 4 entries already stacked still loads `target_i` but drops its push. `stack_ovf_o` is then high for exactly the following cycle, and the stacked entries are unchanged.
- R9: A return made with the stack empty loads the bottom stack entry and leaves the stack empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Next-address code from the decoder |
| target_i | input | 10 | Jump or call destination |
| irq_req_i | input | 3 | Interrupt requests (bit 0 external, bit 1 timer, bit 2 A/D) |
| irq_en_i | input | 3 | Per-source interrupt enables |
| gie_set_i | input | 1 | Set the global interrupt enable |
| gie_clr_i | input | 1 | Clear the global interrupt enable |
| pc_o | output | 10 | Fetch address (program counter) |
| gie_o | output | 1 | Global interrupt enable state |
| pend_o | output | 3 | Pending interrupt flags |
| stack_ovf_o | output | 1 | One-cycle pulse after a call that was made with the stack full |

## Verification
The bench uses the default parameters: a 10-bit counter, a stack depth of 4 and three sources with a vector stride of 4. Because the stack is only four levels deep, four calls fill it. A few cycles are then enough to test the overflow pulse, the empty-stack reload and an interrupt held off by a full stack. With the 10-bit width, a single jump to 3FFh followed by one step tests the wrap.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  typedef enum logic [2:0] {
    OP_HOLD = 3'd0,
    OP_NEXT = 3'd1,
    OP_JUMP = 3'd2,
    OP_CALL = 3'd3,
    OP_RET  = 3'd4,
    OP_RETI = 3'd5
  } seq_op_e;
endpackage

// File: rtl/pcseq_irq_arb.sv
module pcseq_irq_arb #(
  parameter int N_SRC      = 3,
  parameter int PC_W       = 10,
  parameter int VEC_STRIDE = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic             gie_i,
  input  logic             block_i,
  output logic [N_SRC-1:0] pend_o,
  output logic [N_SRC-1:0] ack_vec_o,
  output logic             ack_o,
  output logic [PC_W-1:0]  vec_o
);
  logic [N_SRC-1:0] pend_q;
  logic [N_SRC-1:0] cand;
  logic [PC_W-1:0]  vec_tab [N_SRC];

  for (genvar g = 0; g < N_SRC; g++) begin : g_vec
    assign vec_tab[g] = PC_W'((g + 1) * VEC_STRIDE);
  end

  assign cand = pend_q & en_i & {N_SRC{gie_i & ~block_i}};

  // lowest index wins
  always_comb begin
    ack_vec_o = '0;
    vec_o     = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (cand[i]) begin
        ack_vec_o    = '0;
        ack_vec_o[i] = 1'b1;
        vec_o        = vec_tab[i];
      end
    end
  end

  assign ack_o = |cand;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~ack_vec_o) | req_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/pcseq_ret_stack.sv
module pcseq_ret_stack #(
  parameter int DEPTH = 4,
  parameter int W     = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] top_o,
  output logic         full_o
);
  localparam int SP_W = $clog2(DEPTH + 1);

  logic [SP_W-1:0] sp_q;
  logic [W-1:0]    mem_q [DEPTH];

  assign full_o = (sp_q == SP_W'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_i && !full_o) begin
      for (int i = 0; i < DEPTH; i++)
        if (sp_q == SP_W'(i)) mem_q[i] <= data_i;
      sp_q <= sp_q + 1'b1;
    end else if (pop_i && sp_q != '0) begin
      sp_q <= sp_q - 1'b1;
    end
  end

  // empty stack reads the bottom entry
  always_comb begin
    top_o = mem_q[0];
    for (int i = 0; i < DEPTH; i++)
      if (sp_q == SP_W'(i + 1)) top_o = mem_q[i];
  end
endmodule

// File: rtl/pcseq_top.sv
module pcseq_top
  import pcseq_pkg::*;
#(
  parameter int PC_W        = 10,
  parameter int STACK_DEPTH = 4,
  parameter int N_SRC       = 3,
  parameter int VEC_STRIDE  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       op_i,
  input  logic [PC_W-1:0]  target_i,
  input  logic [N_SRC-1:0] irq_req_i,
  input  logic [N_SRC-1:0] irq_en_i,
  input  logic             gie_set_i,
  input  logic             gie_clr_i,
  output logic [PC_W-1:0]  pc_o,
  output logic             gie_o,
  output logic [N_SRC-1:0] pend_o,
  output logic             stack_ovf_o
);
  seq_op_e          op;
  logic [PC_W-1:0]  pc_q, pc_d, pc_inc, vec_w, top_w, push_data;
  logic [N_SRC-1:0] ack_vec_w;
  logic             ack_w, full_w, push_w, pop_w, gie_q, ovf_q;

  assign op     = seq_op_e'(op_i);
  assign pc_inc = pc_q + 1'b1;

  pcseq_irq_arb #(
    .N_SRC(N_SRC), .PC_W(PC_W), .VEC_STRIDE(VEC_STRIDE)
  ) u_arb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (irq_req_i),
    .en_i     (irq_en_i),
    .gie_i    (gie_q),
    .block_i  (full_w),
    .pend_o   (pend_o),
    .ack_vec_o(ack_vec_w),
    .ack_o    (ack_w),
    .vec_o    (vec_w)
  );

  // interrupt replaces the instruction at pc_q: one stack op per cycle
  assign push_w    = ack_w || (op == OP_CALL);
  assign pop_w     = !ack_w && (op == OP_RET || op == OP_RETI);
  assign push_data = ack_w ? pc_q : pc_inc;

  pcseq_ret_stack #(
    .DEPTH(STACK_DEPTH), .W(PC_W)
  ) u_stack (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .push_i(push_w),
    .pop_i (pop_w),
    .data_i(push_data),
    .top_o (top_w),
    .full_o(full_w)
  );

  always_comb begin
    if (ack_w) pc_d = vec_w;
    else begin
      unique case (op)
        OP_NEXT:          pc_d = pc_inc;
        OP_JUMP, OP_CALL: pc_d = target_i;
        OP_RET, OP_RETI:  pc_d = top_w;
        default:          pc_d = pc_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      gie_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      pc_q  <= pc_d;
      ovf_q <= push_w && full_w && !ack_w;
      if (ack_w)                           gie_q <= 1'b0;
      else if (op == OP_RETI || gie_set_i) gie_q <= 1'b1;
      else if (gie_clr_i)                  gie_q <= 1'b0;
    end
  end

  assign pc_o        = pc_q;
  assign gie_o       = gie_q;
  assign stack_ovf_o = ovf_q;
endmodule

// File: rtl/pcseq_chk.sv
module pcseq_chk #(
  parameter int PC_W  = 10,
  parameter int N_SRC = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       op_i,
  input logic [PC_W-1:0]  pc_o,
  input logic             gie_o,
  input logic             stack_ovf_o,
  input logic             ack_w,
  input logic [N_SRC-1:0] ack_vec_w,
  input logic             full_w
);
  logic [PC_W-1:0] pc_plus;
  assign pc_plus = pc_o + 1'b1;

  // R2
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd0 && !ack_w) |=> $stable(pc_o));
  // R2
  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd1 && !ack_w) |=> pc_o == $past(pc_plus));
  // R4
  a_r4_one_winner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_vec_w));
  // R4
  a_r4_ext_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_vec_w[0] |=> pc_o == PC_W'(4));
  // R5
  a_r5_full_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_w |-> !ack_w);
  // R7
  a_r7_ack_clears_gie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_w |=> !gie_o);
  // R8
  a_r8_ovf_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stack_ovf_o |-> $past(op_i == 3'd3 && full_w));
  // R8
  a_r8_ovf_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd3 && full_w) |=> stack_ovf_o);
endmodule

bind pcseq_top pcseq_chk #(.PC_W(PC_W), .N_SRC(N_SRC)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .op_i       (op_i),
  .pc_o       (pc_o),
  .gie_o      (gie_o),
  .stack_ovf_o(stack_ovf_o),
  .ack_w      (ack_w),
  .ack_vec_w  (ack_vec_w),
  .full_w     (full_w)
);

// File: tb/pcseq_tb.sv
`timescale 1ns/1ps
module pcseq_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] op_i = 3'd0;
  logic [9:0] target_i = '0;
  logic [2:0] irq_req_i = '0;
  logic [2:0] irq_en_i = '0;
  logic       gie_set_i = 1'b0;
  logic       gie_clr_i = 1'b0;
  logic [9:0] pc_o;
  logic       gie_o;
  logic [2:0] pend_o;
  logic       stack_ovf_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  localparam logic [2:0] HOLD = 3'd0, NEXT = 3'd1, JUMP = 3'd2,
                         CALL = 3'd3, RET = 3'd4, RETI = 3'd5;

  always #2.5 clk = ~clk;

  pcseq_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op_i), .target_i(target_i),
    .irq_req_i(irq_req_i), .irq_en_i(irq_en_i), .gie_set_i(gie_set_i),
    .gie_clr_i(gie_clr_i), .pc_o(pc_o), .gie_o(gie_o), .pend_o(pend_o),
    .stack_ovf_o(stack_ovf_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one cycle, sample 1 ns after the edge
  task automatic cyc(input logic [2:0] op, input logic [9:0] tgt = '0);
    op_i = op;
    target_i = tgt;
    @(posedge clk);
    #1;
    op_i = HOLD;
    irq_req_i = '0;
    gie_set_i = 1'b0;
    gie_clr_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 pc", pc_o, 0);
    chk("R1 gie", gie_o, 0);
    chk("R1 pend", pend_o, 0);
    chk("R1 ovf", stack_ovf_o, 0);
  endtask

  task automatic t_seq;
    cyc(NEXT); cyc(NEXT); cyc(NEXT);
    chk("R2 step", pc_o, 3);
    cyc(HOLD);
    chk("R2 hold", pc_o, 3);
    cyc(3'd7);
    chk("R2 code7 holds", pc_o, 3);
    cyc(JUMP, 10'h3FF);
    chk("R2 jump", pc_o, 'h3FF);
    cyc(NEXT);
    chk("R2 wrap", pc_o, 0);
  endtask

  task automatic t_call;
    cyc(JUMP, 10'h010);
    cyc(CALL, 10'h100);
    chk("R3 call1", pc_o, 'h100);
    cyc(CALL, 10'h200);
    chk("R3 call2", pc_o, 'h200);
    cyc(RET);
    chk("R3 ret inner", pc_o, 'h101);
    cyc(RET);
    chk("R3 ret outer", pc_o, 'h011);
  endtask

  task automatic t_ovf;
    cyc(JUMP, 10'h020);
    cyc(CALL, 10'h040);
    cyc(CALL, 10'h050);
    cyc(CALL, 10'h060);
    cyc(CALL, 10'h070);
    chk("R8 no ovf at fill", stack_ovf_o, 0);
    cyc(CALL, 10'h080);
    chk("R8 call still jumps", pc_o, 'h080);
    chk("R8 ovf pulse", stack_ovf_o, 1);
    cyc(HOLD);
    chk("R8 ovf one cycle", stack_ovf_o, 0);
    cyc(RET); chk("R8 ret4", pc_o, 'h061);
    cyc(RET); chk("R3 ret3", pc_o, 'h051);
    cyc(RET); chk("R3 ret2", pc_o, 'h041);
    cyc(RET); chk("R3 ret1", pc_o, 'h021);
    cyc(RET); chk("R9 empty ret", pc_o, 'h021);
    cyc(RET); chk("R9 empty ret again", pc_o, 'h021);
    cyc(NEXT); chk("R2 step", pc_o, 'h022);
  endtask

  task automatic t_prio;
    irq_en_i = 3'b111;
    gie_set_i = 1'b1;
    cyc(HOLD);
    chk("R7 gie set", gie_o, 1);
    irq_req_i = 3'b111;
    cyc(HOLD);
    chk("R6 pend set", pend_o, 'b111);
    chk("R6 pc unchanged", pc_o, 'h022);
    cyc(NEXT);
    chk("R4 ext vector, R5 op ignored", pc_o, 'h004);
    chk("R6 ext cleared only", pend_o, 'b110);
    chk("R7 ack clears gie", gie_o, 0);
    cyc(HOLD);
    chk("R5 gie off blocks", pc_o, 'h004);
    cyc(RETI);
    chk("R5 pushed pc", pc_o, 'h022);
    chk("R7 reti sets gie", gie_o, 1);
    cyc(HOLD);
    chk("R4 timer vector", pc_o, 'h008);
    chk("R6 timer cleared", pend_o, 'b100);
    cyc(RETI);
    cyc(HOLD);
    chk("R4 adc vector", pc_o, 'h00C);
    chk("R6 all cleared", pend_o, 0);
    cyc(RETI);
    chk("R7 reti back", pc_o, 'h022);
  endtask

  task automatic t_mask;
    irq_en_i = 3'b110;
    irq_req_i = 3'b001;
    cyc(HOLD);
    cyc(HOLD);
    chk("R5 masked not taken", pc_o, 'h022);
    chk("R6 masked stays pending", pend_o, 'b001);
    gie_clr_i = 1'b1;
    cyc(HOLD);
    chk("R7 gie clr", gie_o, 0);
    irq_en_i = 3'b111;
    cyc(HOLD);
    chk("R5 gie off no ack", pc_o, 'h022);
    gie_set_i = 1'b1;
    cyc(HOLD);
    chk("R5 ack waits for gie", pc_o, 'h022);
    cyc(HOLD);
    chk("R4 ext taken", pc_o, 'h004);
    cyc(RETI);
    chk("R7 reti", pc_o, 'h022);
  endtask

  task automatic t_full;
    cyc(CALL, 10'h100);
    cyc(CALL, 10'h110);
    cyc(CALL, 10'h120);
    cyc(CALL, 10'h130);
    irq_req_i = 3'b010;
    cyc(HOLD);
    chk("R6 pend timer", pend_o, 'b010);
    cyc(HOLD);
    chk("R5 full blocks ack", pc_o, 'h130);
    cyc(RET);
    chk("R3 ret frees level", pc_o, 'h121);
    cyc(HOLD);
    chk("R5 taken once free", pc_o, 'h008);
    cyc(RETI);
    chk("R5 return to pushed pc", pc_o, 'h121);
    cyc(RET);
    chk("R3 stack intact", pc_o, 'h111);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset;
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    t_reset;
    t_seq;
    t_call;
    t_ovf;
    t_prio;
    t_mask;
    t_full;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule